// File: doc/BRIEF.md
# Keyboard Host-Command Decoder

This block sits between the serial receiver and transmitter of a keyboard controller. It watches the stream of bytes the host sends and picks out escape-led command sequences. One sequence carries a parameter byte that sets the bell and click controls. One switches the keyboard from its power-on ASCII reporting mode to make/break scancode reporting. One runs a reset/diagnostic that returns a two-byte status reply to the host.

Received bytes arrive one per cycle, each marked by a valid strobe. The self-test result is a static input that the block samples when a diagnostic command is taken. Reply bytes leave on a valid/ready handshake toward the transmitter. The configuration controls and the mode are registered levels that the rest of the controller reads directly.

Top module: `kbd_cmd_decoder`

## Requirements
- R1: After reset, all four configuration outputs are 0, `scan_mode` is 0 (ASCII mode) and `tx_valid` is 0.
- R2: Outside a command sequence, every received byte other than 0x1b is ignored. Such a byte changes no output, even when it is 0x42, 0x44 or 0x55.
- R3: The sequence 0x1b, 0x42, P loads the configuration from P in the cycle after P is received: `bell_en`=P[0], `key_click_en`=P[2], `membrane_click_en`=P[3], `bell_loud`=P[5]. The other bits of P are ignored.
- R4: A 0x1b received as the parameter byte P is applied as configuration data and does not start a new sequence. The decoder is back outside a sequence once P has been applied.
- R5: The sequence 0x1b, 0x55 sets `scan_mode` to 1 in the cycle after 0x55 is received, and it stays 1 until a diagnostic command or reset.
- R6: The sequence 0x1b, 0x44 raises `tx_valid` in the next cycle, with `tx_data`=0xff as the first reply byte.
- R7: The second reply byte equals `selftest_status` AND 0x38, sampled in the cycle the 0x44 is received. Bit 3 reports an EPROM checksum failure, bit 4 a RAM error and bit 5 a ROM checksum failure, and 0x00 means pass.
- R8: A reply byte stays on `tx_data`, with `tx_valid` high, until a cycle in which `tx_ready` is high. The second byte follows only after the first has been accepted, and `tx_valid` falls after the second has been accepted.
- R9: The diagnostic command clears all four configuration outputs and returns `scan_mode` to 0 in the cycle after 0x44 is received.
- R10: A command byte other than 0x42, 0x44 or 0x55 ends the sequence without any output change and without sending anything. The byte after it is treated as outside a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| selftest_status | input | 8 | Self-test failure flags |
| tx_ready | input | 1 | Transmitter accepts `tx_data` this cycle |
| tx_data | output | 8 | Reply byte to transmit |
| tx_valid | output | 1 | Reply byte pending |
| bell_en | output | 1 | Bell enable |
| key_click_en | output | 1 | Key click enable |
| membrane_click_en | output | 1 | Membrane click enable |
| bell_loud | output | 1 | Bell volume: 1 loud, 0 off |
| scan_mode | output | 1 | 1 scancode make/break mode, 0 ASCII mode |

## Verification
The bench sends an escape byte as the parameter value. A parser that restarted the sequence there would leave the configuration unchanged and then act on the following byte as a command. It sends command codes while outside a sequence, which a decoder that did not track position would wrongly execute. It holds off `tx_ready` across the reply, which exposes a sequencer that drops or skips the first byte. It changes the self-test input after the diagnostic command, which catches a design that reads the status late instead of latching it. It also checks that the reserved status bits are masked out.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ESC_CODE  = 8'h1b;
  localparam logic [BYTE_W-1:0] CMD_CFG   = 8'h42;
  localparam logic [BYTE_W-1:0] CMD_DIAG  = 8'h44;
  localparam logic [BYTE_W-1:0] CMD_SCAN  = 8'h55;
  localparam logic [BYTE_W-1:0] REPLY_LEAD = 8'hff;
  localparam logic [BYTE_W-1:0] STAT_MASK = 8'h38;

  localparam int NCFG = 4;
  // bit positions in the parameter byte, index order matches cfg_t (lsb first)
  localparam int CFG_POS [NCFG] = '{0, 2, 3, 5};

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_CMD,
    PS_PARAM
  } parse_st_e;

  typedef struct packed {
    logic loud;
    logic mem_click;
    logic key_click;
    logic bell;
  } cfg_t;
endpackage

// File: rtl/kbd_cmd_parser.sv
module kbd_cmd_parser
  import kbd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              cfg_load,
  output logic              diag_go,
  output logic              scan_go
);
  parse_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cfg_load = 1'b0;
    diag_go  = 1'b0;
    scan_go  = 1'b0;
    if (rx_valid) begin
      unique case (st_q)
        PS_IDLE: begin
          if (rx_data == ESC_CODE) st_d = PS_CMD;
        end
        PS_CMD: begin
          st_d = PS_IDLE;
          if (rx_data == CMD_CFG)       st_d = PS_PARAM;
          else if (rx_data == CMD_DIAG) diag_go = 1'b1;
          else if (rx_data == CMD_SCAN) scan_go = 1'b1;
        end
        PS_PARAM: begin
          cfg_load = 1'b1;
          st_d     = PS_IDLE;
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/kbd_cfg_reg.sv
module kbd_cfg_reg
  import kbd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              diag_go,
  input  logic              scan_go,
  input  logic [BYTE_W-1:0] param_byte,
  output cfg_t              cfg,
  output logic              scan_mode
);
  logic [NCFG-1:0] pick;
  logic [NCFG-1:0] cfg_q, cfg_d;
  logic            mode_q, mode_d;
  logic            cfg_en, mode_en;

  for (genvar i = 0; i < NCFG; i++) begin : g_pick
    assign pick[i] = param_byte[CFG_POS[i]];
  end

  always_comb begin
    cfg_en  = cfg_load | diag_go;
    mode_en = scan_go | diag_go;
    cfg_d   = diag_go ? '0 : pick;
    mode_d  = scan_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign cfg       = cfg_t'(cfg_q);
  assign scan_mode = mode_q;
endmodule

// File: rtl/kbd_reply_seq.sv
module kbd_reply_seq
  import kbd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid
);
  localparam int NREPLY = 2;
  localparam int CW = $clog2(NREPLY + 1);

  logic [CW-1:0]     left_q, left_d;
  logic [BYTE_W-1:0] stat_q;
  logic              take;

  always_comb begin
    take   = (left_q != '0) && tx_ready;
    left_d = left_q;
    if (start)     left_d = CW'(NREPLY);
    else if (take) left_d = left_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      stat_q <= '0;
    end else begin
      left_q <= left_d;
      if (start) stat_q <= status_in & STAT_MASK;
    end
  end

  assign tx_valid = (left_q != '0);
  assign tx_data  = (left_q == CW'(NREPLY)) ? REPLY_LEAD : stat_q;
endmodule

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder
  import kbd_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  input  logic [7:0] selftest_status,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       bell_en,
  output logic       key_click_en,
  output logic       membrane_click_en,
  output logic       bell_loud,
  output logic       scan_mode
);
  logic cfg_load, diag_go, scan_go;
  cfg_t cfg;

  kbd_cmd_parser u_parse (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .cfg_load(cfg_load), .diag_go(diag_go), .scan_go(scan_go)
  );

  kbd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .diag_go(diag_go),
    .scan_go(scan_go), .param_byte(rx_data), .cfg(cfg), .scan_mode(scan_mode)
  );

  kbd_reply_seq u_reply (
    .clk(clk), .rst_n(rst_n), .start(diag_go), .status_in(selftest_status),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid)
  );

  assign bell_en           = cfg.bell;
  assign key_click_en      = cfg.key_click;
  assign membrane_click_en = cfg.mem_click;
  assign bell_loud         = cfg.loud;
endmodule

// File: rtl/kbd_cmd_chk.sv
module kbd_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic [7:0] selftest_status,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       bell_en,
  input logic       key_click_en,
  input logic       membrane_click_en,
  input logic       bell_loud,
  input logic       scan_mode
);
  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rx_valid) |=> (tx_valid && $stable(tx_data)));

  // R7
  stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_data != 8'hff) |-> ((tx_data & 8'hc7) == 8'h00));

  // R5
  scan_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_mode) |-> ($past(rx_valid) && $past(rx_data) == 8'h55));

  // R9
  mode_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_mode) |-> ($past(rx_valid) && $past(rx_data) == 8'h44));

  // R3
  cfg_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({bell_en, key_click_en, membrane_click_en, bell_loud}) |-> $past(rx_valid));

  // R6
  reply_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_data == 8'hff));
endmodule

bind kbd_cmd_decoder kbd_cmd_chk u_chk (.*);

// File: tb/sim_kbd_cmd_decoder.sv
`timescale 1ns/1ps
module sim_kbd_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [7:0] selftest_status;
  logic       tx_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       bell_en, key_click_en, membrane_click_en, bell_loud, scan_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  kbd_cmd_decoder u0 (.*);

  // {rx byte, expected {loud,mem,key,bell}, expected scan_mode}
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    {8'h42, 4'b0000, 1'b0},  // R2 idle ignores
    {8'h55, 4'b0000, 1'b0},  // R2
    {8'h1b, 4'b0000, 1'b0},
    {8'h42, 4'b0000, 1'b0},
    {8'hff, 4'b1111, 1'b0},  // R3
    {8'h1b, 4'b1111, 1'b0},
    {8'h42, 4'b1111, 1'b0},
    {8'h05, 4'b0011, 1'b0},  // R3
    {8'h1b, 4'b0011, 1'b0},
    {8'h42, 4'b0011, 1'b0},
    {8'h28, 4'b1100, 1'b0},  // R3
    {8'h1b, 4'b1100, 1'b0},
    {8'h55, 4'b1100, 1'b1},  // R5
    {8'h1b, 4'b1100, 1'b1},
    {8'h99, 4'b1100, 1'b1},  // R10 unknown command
    {8'h42, 4'b1100, 1'b1},  // R10 next byte is outside a sequence
    {8'h1b, 4'b1100, 1'b1},
    {8'h42, 4'b1100, 1'b1},
    {8'h1b, 4'b0101, 1'b1},  // R4 escape taken as parameter
    {8'h42, 4'b0101, 1'b1}   // R4 back outside a sequence
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [3:0] cfg_now();
    return {bell_loud, membrane_click_en, key_click_en, bell_en};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rx_data = '0; rx_valid = 1'b0; selftest_status = '0; tx_ready = 1'b1;
    do_reset();
    // R1
    check("R1 cfg", {4'b0, cfg_now()}, 8'h00);
    check("R1 mode", {7'b0, scan_mode}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][12:5]);
      check($sformatf("vec%0d cfg", i), {4'b0, cfg_now()}, {4'b0, VEC[i][4:1]});
      check($sformatf("vec%0d mode", i), {7'b0, scan_mode}, {7'b0, VEC[i][0]});
      check($sformatf("vec%0d R10 no reply", i), {7'b0, tx_valid}, 8'h00);
    end

    // R2: command codes outside a sequence with ASCII mode active
    do_reset();
    send(8'h55); send(8'h44);
    check("R2 mode", {7'b0, scan_mode}, 8'h00);
    check("R2 no reply", {7'b0, tx_valid}, 8'h00);

    // diagnostic with stalled transmitter
    selftest_status = 8'hff;
    tx_ready = 1'b0;
    send(8'h1b); send(8'h42); send(8'h2d);
    send(8'h1b); send(8'h55);
    check("R5 mode set", {7'b0, scan_mode}, 8'h01);
    send(8'h1b); send(8'h44);
    check("R6 tx_valid", {7'b0, tx_valid}, 8'h01);
    check("R6 lead byte", tx_data, 8'hff);
    check("R9 cfg cleared", {4'b0, cfg_now()}, 8'h00);
    check("R9 mode ascii", {7'b0, scan_mode}, 8'h00);
    repeat (3) @(negedge clk);
    check("R8 held valid", {7'b0, tx_valid}, 8'h01);
    check("R8 held data", tx_data, 8'hff);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R8 second valid", {7'b0, tx_valid}, 8'h01);
    check("R7 masked status", tx_data, 8'h38);
    @(negedge clk);
    check("R8 done", {7'b0, tx_valid}, 8'h00);

    // R7: status latched at command time
    selftest_status = 8'h10;
    tx_ready = 1'b0;
    send(8'h1b); send(8'h44);
    selftest_status = 8'hff;
    check("R6 lead again", tx_data, 8'hff);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R7 latched status", tx_data, 8'h10);
    @(negedge clk);
    check("R8 done again", {7'b0, tx_valid}, 8'h00);

    // R7: pass status
    selftest_status = 8'h00;
    send(8'h1b); send(8'h44);
    check("R6 lead pass", tx_data, 8'hff);
    @(negedge clk);
    check("R7 pass status", tx_data, 8'h00);
    check("R7 pass valid", {7'b0, tx_valid}, 8'h01);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule